// File: doc/BRIEF.md
# Serial Control Register Port

This block is a slave port for a three-wire serial control bus: an active-high select, a serial clock driven by the bus master, and one data line that changes direction during reads. Behind the port sits a bank of eight-bit control registers. The first 22 can be written. Address 22 cannot be written and returns a status byte supplied by the surrounding logic. The block runs on its own system clock. It passes the three bus pins through synchronizers and works from the detected serial clock edges.

Every access starts with a header octet: a seven-bit register address, most significant bit first, then a direction bit. Data octets follow, and the address moves up by one after each octet. Written octets go to a staging copy of the bank. They reach the active registers, which the port exposes as a flat vector, only through a one-cycle load pulse made when the select line is released. A load-enable bit in register 0 can hold that pulse back, so that several separate bursts can be committed together.

Only the master clocks the serial data, so the port has no back-pressure. Every pin is a plain level, and the active-register vector and the load pulse are plain outputs too.

Top module: `tw_ctrl_port`

## Requirements
- R1: The select input is active high. While it is low, serial clock and data activity are ignored and the frame state is cleared, so the next selected frame is decoded from its first bit.
- R2: The data line is sampled on falling serial clock edges. The first octet carries the address in bits 7:1 and the direction in bit 0, where 0 means write and 1 means read. Every octet is sent most significant bit first.
- R3: Each data octet after the header goes to the next higher address, starting at the header address.
- R4: Written octets reach the active registers only through a single-cycle load pulse. The pulse comes in the second system cycle after the synchronized select is seen low, and only at the end of a frame whose header was a write.
- R5: The load pulse is suppressed when bit 0 of the staged copy of register 0 is 0 at release time. Writing that bit back to 1 in a later frame commits every staged value in one pulse.
- R6: In a read, the data line output enable rises on the first rising serial clock edge after the direction bit. Read data changes on rising edges, most significant bit first, and comes from the active registers. A read changes no register and makes no load pulse.
- R7: Address 22 reads back the status input. Writes to address 22 and above are discarded and leave every active register unchanged.
- R8: Fixed bits always hold their fixed values, after reset and after any write: register 1 bits 5:4 = 00, register 2 bit 5 = 0, register 3 bits 7:5 = 110, register 5 bits 5:4 = 01, register 8 bits 7:5 = 110, register 9 bits 7:5 = 001, and register 20 = 8'hA3.
- R9: If select drops before the eighth bit of an octet, that partial octet is discarded. Complete octets of the same frame are still committed.
- R10: The data line output enable is low whenever the select input is low, with no synchronizer delay.
- R11: At reset, register 0 is 8'h01: mode bits 2:1 are 00 (power-down) and load enable is 1. All bits that are not fixed are 0, and the output enable is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_i | input | 1 | Serial select, active high |
| sclk_i | input | 1 | Serial clock from the master |
| sdio_i | input | 1 | Data line value seen at the pad |
| sdio_o | output | 1 | Read data driven toward the pad |
| sdio_oe | output | 1 | Pad output enable for the data line |
| status_i | input | 8 | Status byte returned at address 22 |
| cfg_o | output | 176 | Active registers 0 to 21, register n at bits 8n+7:8n |
| load_pulse_o | output | 1 | One-cycle pulse when staged values are committed |

## Verification
A write to register 0 can clear or set the load-enable bit inside the same frame whose release that bit decides. The bench provokes this by staging 0 into the bit, staging a second register, and then writing the bit back to 1. It judges the result from the count of load pulses and from the active values read back through cfg_o and over the serial line. Release of select can also land in the same cycle as a partial octet. The bench ends a frame four bits into its second data octet and expects the first octet to be committed and the partial one to leave no trace.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int LOAD_EN_BIT = 0;

  // Bits of each register that hold fixed values.
  function automatic logic [7:0] fixed_mask(input int idx);
    case (idx)
      1:       return 8'h30;
      2:       return 8'h20;
      3:       return 8'hE0;
      5:       return 8'h30;
      8:       return 8'hE0;
      9:       return 8'hE0;
      20:      return 8'hFF;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] fixed_val(input int idx);
    case (idx)
      3:       return 8'hC0;
      5:       return 8'h10;
      8:       return 8'hC0;
      9:       return 8'h20;
      20:      return 8'hA3;
      default: return 8'h00;
    endcase
  endfunction

  // Register 0 resets to power-down mode with load enable set.
  function automatic logic [7:0] reset_val(input int idx);
    if (idx == 0) return 8'h01;
    return fixed_val(idx);
  endfunction
endpackage

// File: rtl/tw_edge_sync.sv
module tw_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_i,
  input  logic sclk_i,
  input  logic sdio_i,
  output logic cs_s,
  output logic sdio_s,
  output logic cs_fall,
  output logic sclk_rise,
  output logic sclk_fall
);
  logic [STAGES-1:0] cs_ff, sclk_ff, sdio_ff;
  logic              sclk_prev, cs_prev;
  logic              sclk_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_ff     <= '0;
      sclk_ff   <= '0;
      sdio_ff   <= '0;
      sclk_prev <= 1'b0;
      cs_prev   <= 1'b0;
    end else begin
      cs_ff     <= {cs_ff[STAGES-2:0], cs_i};
      sclk_ff   <= {sclk_ff[STAGES-2:0], sclk_i};
      sdio_ff   <= {sdio_ff[STAGES-2:0], sdio_i};
      sclk_prev <= sclk_ff[STAGES-1];
      cs_prev   <= cs_ff[STAGES-1];
    end
  end

  assign cs_s      = cs_ff[STAGES-1];
  assign sclk_s    = sclk_ff[STAGES-1];
  assign sdio_s    = sdio_ff[STAGES-1];
  assign cs_fall   = cs_prev & ~cs_s;
  assign sclk_rise = cs_s & sclk_s & ~sclk_prev;
  assign sclk_fall = cs_s & ~sclk_s & sclk_prev;
endmodule

// File: rtl/tw_frame_engine.sv
module tw_frame_engine #(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_s,
  input  logic          cs_fall,
  input  logic          sclk_rise,
  input  logic          sclk_fall,
  input  logic          sdio_s,
  input  logic [DW-1:0] lookup_data,
  output logic [AW-1:0] lookup_addr,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          release_wr,
  output logic          sdio_q,
  output logic          oe_q
);
  localparam int CW = $clog2(DW);
  localparam logic [CW-1:0] LAST_BIT = CW'(DW - 1);

  logic [CW-1:0] bit_cnt;
  logic [DW-2:0] sh;
  logic [DW-1:0] octet;
  logic [DW-1:0] rd_sh;
  logic [AW-1:0] addr;
  logic          hdr_done;
  logic          rw;
  logic          octet_end;

  assign octet       = {sh, sdio_s};
  assign octet_end   = sclk_fall && (bit_cnt == LAST_BIT);
  assign lookup_addr = hdr_done ? addr + 1'b1 : octet[DW-1:1];
  assign wr_en       = octet_end && hdr_done && !rw;
  assign wr_addr     = addr;
  assign wr_data     = octet;
  assign release_wr  = cs_fall && hdr_done && !rw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt  <= '0;
      sh       <= '0;
      rd_sh    <= '0;
      addr     <= '0;
      hdr_done <= 1'b0;
      rw       <= 1'b0;
      sdio_q   <= 1'b0;
      oe_q     <= 1'b0;
    end else if (!cs_s) begin
      bit_cnt  <= '0;
      hdr_done <= 1'b0;
      oe_q     <= 1'b0;
    end else begin
      if (sclk_fall) begin
        sh      <= octet[DW-2:0];
        bit_cnt <= bit_cnt + 1'b1;
        if (octet_end) begin
          if (!hdr_done) begin
            addr     <= octet[DW-1:1];
            rw       <= octet[0];
            hdr_done <= 1'b1;
            if (octet[0]) rd_sh <= lookup_data;
          end else begin
            if (addr != '1) addr <= addr + 1'b1;
            if (rw) rd_sh <= lookup_data;
          end
        end
      end
      if (sclk_rise && hdr_done && rw) begin
        oe_q   <= 1'b1;
        sdio_q <= rd_sh[DW-1];
        rd_sh  <= {rd_sh[DW-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/tw_reg_bank.sv
module tw_reg_bank
  import tw_pkg::*;
#(
  parameter int NWR = 22,
  parameter int AW  = 7,
  parameter int DW  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic              load_req,
  input  logic [DW-1:0]     status_i,
  input  logic [AW-1:0]     lookup_addr,
  output logic [DW-1:0]     lookup_data,
  output logic [NWR*DW-1:0] active_flat,
  output logic              load_pulse
);
  logic [DW-1:0] staged [NWR];
  logic [DW-1:0] active [NWR];
  logic          load_fire;

  assign load_fire = load_req & staged[0][LOAD_EN_BIT];

  for (genvar g = 0; g < NWR; g++) begin : g_reg
    localparam logic [DW-1:0] MASK = DW'(fixed_mask(g));
    localparam logic [DW-1:0] FVAL = DW'(fixed_val(g));
    localparam logic [DW-1:0] RVAL = DW'(reset_val(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        staged[g] <= RVAL;
        active[g] <= RVAL;
      end else begin
        if (wr_en && (wr_addr == AW'(g)))
          staged[g] <= (wr_data & ~MASK) | (FVAL & MASK);
        if (load_fire)
          active[g] <= staged[g];
      end
    end

    assign active_flat[g*DW +: DW] = active[g];
  end

  always_comb begin
    lookup_data = '0;
    for (int i = 0; i < NWR; i++)
      if (lookup_addr == AW'(i)) lookup_data = active[i];
    if (lookup_addr == AW'(NWR)) lookup_data = status_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) load_pulse <= 1'b0;
    else        load_pulse <= load_fire;
  end
endmodule

// File: rtl/tw_ctrl_port.sv
module tw_ctrl_port #(
  parameter int NUM_REGS    = 23,
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cs_i,
  input  logic                           sclk_i,
  input  logic                           sdio_i,
  output logic                           sdio_o,
  output logic                           sdio_oe,
  input  logic [DATA_W-1:0]              status_i,
  output logic [(NUM_REGS-1)*DATA_W-1:0] cfg_o,
  output logic                           load_pulse_o
);
  localparam int NUM_WR = NUM_REGS - 1;

  logic              cs_sync, sdio_sync, cs_fall, sclk_rise, sclk_fall;
  logic [DATA_W-1:0] lookup_data, wr_data;
  logic [ADDR_W-1:0] lookup_addr, wr_addr;
  logic              wr_en, release_wr, rd_oe;

  tw_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .cs_i(cs_i), .sclk_i(sclk_i), .sdio_i(sdio_i),
    .cs_s(cs_sync), .sdio_s(sdio_sync), .cs_fall(cs_fall),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall)
  );

  tw_frame_engine #(.AW(ADDR_W), .DW(DATA_W)) u_engine (
    .clk(clk), .rst_n(rst_n), .cs_s(cs_sync), .cs_fall(cs_fall),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .sdio_s(sdio_sync),
    .lookup_data(lookup_data), .lookup_addr(lookup_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .release_wr(release_wr), .sdio_q(sdio_o), .oe_q(rd_oe)
  );

  tw_reg_bank #(.NWR(NUM_WR), .AW(ADDR_W), .DW(DATA_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .load_req(release_wr), .status_i(status_i),
    .lookup_addr(lookup_addr), .lookup_data(lookup_data),
    .active_flat(cfg_o), .load_pulse(load_pulse_o)
  );

  assign sdio_oe = rd_oe & cs_i;
endmodule

// File: rtl/tw_ctrl_port_chk.sv
module tw_ctrl_port_chk #(
  parameter int CFG_W     = 176,
  parameter int FIXED_REG = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_i,
  input logic             sdio_oe,
  input logic             load_pulse_o,
  input logic [CFG_W-1:0] cfg_o,
  input logic             cs_sync,
  input logic             sclk_rise,
  input logic             rd_oe
);
  AST_OE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    sdio_oe |-> cs_i); // R10

  AST_LOAD_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    load_pulse_o |-> (!$past(cs_sync) && $past(cs_sync, 2))); // R4

  AST_LOAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    load_pulse_o |=> !load_pulse_o); // R4

  AST_ACTIVE_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_o) |-> load_pulse_o); // R4

  AST_FIXED_REGISTER: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_o[FIXED_REG*8 +: 8] == 8'hA3); // R8

  AST_OE_ON_RISING: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_oe) |-> $past(sclk_rise)); // R6
endmodule

bind tw_ctrl_port tw_ctrl_port_chk #(.CFG_W((NUM_REGS-1)*DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_i(cs_i), .sdio_oe(sdio_oe),
  .load_pulse_o(load_pulse_o), .cfg_o(cfg_o), .cs_sync(cs_sync),
  .sclk_rise(sclk_rise), .rd_oe(rd_oe)
);

// File: tb/test_tw_ctrl_port.sv
`timescale 1ns/1ps
module test_tw_ctrl_port;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cs = 1'b0, sclk = 1'b0, sdio = 1'b0;
  logic [7:0]   status = 8'h6B;
  logic         sdio_o, sdio_oe, load_pulse;
  logic [175:0] cfg;
  int total = 0, bad = 0, loads = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tw_ctrl_port i_tw_ctrl_port (
    .clk(clk), .rst_n(rst_n), .cs_i(cs), .sclk_i(sclk), .sdio_i(sdio),
    .sdio_o(sdio_o), .sdio_oe(sdio_oe), .status_i(status), .cfg_o(cfg),
    .load_pulse_o(load_pulse)
  );

  always @(posedge clk) if (load_pulse) loads++;

  // address, written value, expected active value
  localparam logic [22:0] VEC [6] = '{
    {7'd2,  8'hFF, 8'hDF},
    {7'd7,  8'h5A, 8'h5A},
    {7'd3,  8'h00, 8'hC0},
    {7'd20, 8'h00, 8'hA3},
    {7'd21, 8'h3C, 8'h3C},
    {7'd1,  8'hFF, 8'hCF}
  };

  function automatic logic [7:0] reg_at(input int a);
    return cfg[a*8 +: 8];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_out(input logic b);
    sdio = b; wait_clk(4); sclk = 1'b1; wait_clk(8); sclk = 1'b0; wait_clk(4);
  endtask

  task automatic byte_out(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
  endtask

  task automatic frame_begin(input logic [6:0] a, input logic rw);
    cs = 1'b1; wait_clk(6); byte_out({a, rw});
  endtask

  task automatic frame_end();
    wait_clk(4); cs = 1'b0; wait_clk(12);
  endtask

  task automatic byte_in(output logic [7:0] v, output logic oe_seen);
    oe_seen = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      sclk = 1'b1; wait_clk(8);
      v[i] = sdio_o; oe_seen &= sdio_oe;
      sclk = 1'b0; wait_clk(8);
    end
  endtask

  task automatic write1(input logic [6:0] a, input logic [7:0] d);
    frame_begin(a, 1'b0); byte_out(d); frame_end();
  endtask

  task automatic read1(input logic [6:0] a, output logic [7:0] v);
    logic oe;
    frame_begin(a, 1'b1); byte_in(v, oe); frame_end();
  endtask

  initial begin
    logic [7:0] v, v2, v3;
    logic oe;
    int l0;
    wait_clk(5); rst_n = 1'b1; wait_clk(3);

    // Reset state
    check("R11 reg0", reg_at(0), 8'h01);
    check("R11 reg3", reg_at(3), 8'hC0);
    check("R8 reg20 reset", reg_at(20), 8'hA3);
    check("R11 oe", sdio_oe, 1'b0);

    // Activity with select low is ignored
    for (int i = 0; i < 10; i++) begin
      sdio = i[0]; sclk = 1'b1; wait_clk(6); sclk = 1'b0; wait_clk(6);
    end
    check("R1 no load while idle", loads, 0);

    // Vector table: single-register writes, checked at the port and by read-back
    foreach (VEC[k]) begin
      write1(VEC[k][22:16], VEC[k][15:8]);
      check("R2 R8 active value", reg_at(int'(VEC[k][22:16])), VEC[k][7:0]);
      read1(VEC[k][22:16], v);
      check("R6 read back", v, VEC[k][7:0]);
    end
    check("R1 load count", loads, 6);

    // Burst write with auto-increment
    frame_begin(7'd10, 1'b0); byte_out(8'h11); byte_out(8'h22); byte_out(8'h33); frame_end();
    check("R3 reg10", reg_at(10), 8'h11);
    check("R3 reg11", reg_at(11), 8'h22);
    check("R3 reg12", reg_at(12), 8'h33);

    // Burst read, output enable, no load from a read
    l0 = loads;
    frame_begin(7'd10, 1'b1);
    check("R6 oe off before first rise", sdio_oe, 1'b0);
    byte_in(v, oe); check("R6 oe during read", oe, 1'b1);
    byte_in(v2, oe); byte_in(v3, oe);
    wait_clk(4); cs = 1'b0; #1;
    check("R10 oe drops with select", sdio_oe, 1'b0);
    wait_clk(12);
    check("R3 R6 burst read", {v, v2, v3}, 24'h112233);
    check("R6 read makes no load", loads, l0);

    // Status register and discarded writes
    status = 8'hC4;
    frame_begin(7'd21, 1'b0); byte_out(8'h77); byte_out(8'hEE); byte_out(8'h55); frame_end();
    check("R7 reg21 written", reg_at(21), 8'h77);
    check("R7 reg0 untouched", reg_at(0), 8'h01);
    read1(7'd22, v);
    check("R7 status read", v, 8'hC4);
    write1(7'd22, 8'hFF);
    read1(7'd22, v);
    check("R7 write to 22 discarded", v, 8'hC4);
    check("R7 reg21 unchanged", reg_at(21), 8'h77);

    // Grouped commit through load enable
    l0 = loads;
    write1(7'd0, 8'h00);
    write1(7'd7, 8'h99);
    check("R5 no pulse while disabled", loads, l0);
    check("R5 reg7 still old", reg_at(7), 8'h5A);
    read1(7'd7, v);
    check("R6 read returns active", v, 8'h5A);
    write1(7'd0, 8'h03);
    check("R5 one pulse on re-enable", loads, l0 + 1);
    check("R5 reg7 committed", reg_at(7), 8'h99);
    check("R5 reg0 committed", reg_at(0), 8'h03);

    // Partial octet dropped at release
    frame_begin(7'd8, 1'b0); byte_out(8'h1F);
    for (int i = 0; i < 4; i++) bit_out(1'b1);
    frame_end();
    check("R9 R8 reg8 written", reg_at(8), 8'hDF);
    check("R9 reg9 untouched", reg_at(9), 8'h20);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule